// File: doc/BRIEF.md
# Multi-Domain Hardware Semaphore Gate Bank

This block holds a bank of hardware semaphore gates that several bus masters share. Each master tags its accesses with a master index and a domain ID. A master claims a gate by writing its own tag, which is its master index plus one, into the gate. It then reads the gate back. If the read-back shows its tag, the master owns the gate. Otherwise another master got there first and the write changed nothing. A locked gate also records the domain of its owner, so any master can find out which domain holds it.

Gates can also be cleared by force through a guarded reset register. The first write must carry an arming key and the second a firing key, and the second write also names a gate. A gate number inside the bank clears that gate. A number at or above the gate count clears every gate. While the sequence waits for its second write, a status field reads nonzero.

Reads are combinational on the address. Writes take effect at the clock edge on which `wrEn` is sampled high.

Top module: `semaGateBank`

## Requirements
- R1: After reset every gate reads 0 and the reset register reads 0.
- R2: A gate read returns the owner tag in bits [3:0] and the owner domain in bits [5:4], with all higher bits 0. A write to an unlocked gate whose wrData[3:0] is nonzero and equals masterIdx+1 locks it with that tag and the writer's domainId.
- R3: A write to an unlocked gate whose wrData[3:0] differs from masterIdx+1 leaves the gate unlocked and reading 0.
- R4: A write from any master other than the owner to a locked gate, whether it carries a tag or zero, leaves the gate value unchanged.
- R5: The owner (stored tag equal to masterIdx+1) unlocks its gate by writing wrData[3:0]=0, after which the gate reads 0.
- R6: Gates sit at addresses 0 to NUM_GATES-1 and the reset register sits at address NUM_GATES. Writes to any higher address are ignored, and reads from any higher address return 0.
- R7: While the reset sequence is idle, a write of key 0xE2 in wrData[7:0] to the reset register arms it. Reset-register bits [1:0] then read 1. While idle, any other key is ignored.
- R8: While armed, a write of key 0x1D carrying a gate number below NUM_GATES in wrData[15:8] clears only that gate and returns the status to 0.
- R9: While armed, a write of key 0x1D carrying a gate number of NUM_GATES or more clears every gate.
- R10: While armed, a reset-register write with any key other than 0x1D returns the status to 0 and clears nothing.
- R11: Gate writes made while the sequence is armed leave it armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Register address (gates, then the reset register) |
| wrData | input | 16 | Write data: the tag or key in [7:0], the reset gate number in [15:8] |
| masterIdx | input | TAG_W | Index of the master making the access |
| domainId | input | DOM_W | Domain of the master making the access |
| rdData | output | 16 | Read data for the addressed register |

## Verification
Every write lands on the rising edge where `wrEn` is high, and because the read path is combinational, its result is visible as soon as that edge has passed. The bench drives a write for one cycle from the falling edge. On the following falling edge it points the address at the affected register, waits a small delay, and compares against its own model. So each gate value, and the reset status, is checked exactly one edge after the write that changed it. Lock races, clears of a single gate or of all gates, and aborted key sequences are all checked at that same one-edge latency.

// File: rtl/semaPkg.sv
package semaPkg;
  localparam int DATA_W = 16;
  localparam logic [7:0] KEY_ARM  = 8'hE2;
  localparam logic [7:0] KEY_FIRE = 8'h1D;

  typedef enum logic {RS_IDLE = 1'b0, RS_ARMED = 1'b1} rstState_t;

  typedef struct packed {
    logic gateWr;
    logic clrOne;
    logic clrAll;
  } semaStrobes_t;
endpackage

// File: rtl/semaCtrl.sv
module semaCtrl
  import semaPkg::*;
#(
  parameter int NUM_GATES = 16,
  parameter int ADDR_W    = $clog2(NUM_GATES + 1),
  parameter int GIDX_W    = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output semaStrobes_t        strb,
  output logic [GIDX_W-1:0]   clrIdx,
  output logic                busy
);
  rstState_t state, nextState;
  logic gateHit, rstHit;
  logic [7:0] keyVal, gateNum;

  assign keyVal  = wrData[7:0];
  assign gateNum = wrData[15:8];
  assign gateHit = addr < ADDR_W'(NUM_GATES);
  assign rstHit  = addr == ADDR_W'(NUM_GATES);
  assign clrIdx  = gateNum[GIDX_W-1:0];
  assign busy    = (state == RS_ARMED);

  always_comb begin
    strb        = '0;
    nextState   = state;
    strb.gateWr = wrEn && gateHit;
    if (wrEn && rstHit) begin
      case (state)
        RS_IDLE: if (keyVal == KEY_ARM) nextState = RS_ARMED;
        default: begin
          nextState = RS_IDLE;
          if (keyVal == KEY_FIRE) begin
            if (gateNum >= 8'(NUM_GATES)) strb.clrAll = 1'b1;
            else                          strb.clrOne = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= RS_IDLE;
    else       state <= nextState;
  end

  // R8 / R9: a clear only ever fires from the armed state
  a_r8_clear_needs_armed: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrOne || strb.clrAll) |-> busy);
  // R10: any second write returns the sequence to idle
  a_r10_second_write_idles: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && rstHit) |=> !busy);
  // R11: gate traffic does not disturb the armed state
  a_r11_gate_write_keeps_armed: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(wrEn && rstHit)) |=> busy);
endmodule

// File: rtl/semaGates.sv
module semaGates
  import semaPkg::*;
#(
  parameter int NUM_GATES = 16,
  parameter int TAG_W     = 4,
  parameter int DOM_W     = 2,
  parameter int ADDR_W    = $clog2(NUM_GATES + 1),
  parameter int GIDX_W    = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  semaStrobes_t        strb,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [TAG_W-1:0]    wrTag,
  input  logic [TAG_W-1:0]    masterIdx,
  input  logic [DOM_W-1:0]    domainId,
  input  logic [GIDX_W-1:0]   clrIdx,
  input  logic                busy,
  output logic [DATA_W-1:0]   rdData
);
  localparam int GATE_W = TAG_W + DOM_W;

  logic [TAG_W-1:0] tagQ [NUM_GATES];
  logic [DOM_W-1:0] domQ [NUM_GATES];
  logic [TAG_W:0]   ownTag;

  assign ownTag = {1'b0, masterIdx} + (TAG_W + 1)'(1);

  for (genvar g = 0; g < NUM_GATES; g++) begin : gGate
    logic sel, lockOk, unlockOk, clr;
    assign sel      = strb.gateWr && (addr == ADDR_W'(g));
    assign lockOk   = sel && (tagQ[g] == '0) && (wrTag != '0) && ({1'b0, wrTag} == ownTag);
    assign unlockOk = sel && (tagQ[g] != '0) && (wrTag == '0) && ({1'b0, tagQ[g]} == ownTag);
    assign clr      = strb.clrAll || (strb.clrOne && (clrIdx == GIDX_W'(g)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagQ[g] <= '0;
        domQ[g] <= '0;
      end else if (clr || unlockOk) begin
        tagQ[g] <= '0;
        domQ[g] <= '0;
      end else if (lockOk) begin
        tagQ[g] <= wrTag;
        domQ[g] <= domainId;
      end
    end

    // R4: a held gate never passes straight to another owner
    a_r4_no_takeover: assert property (@(posedge clk) disable iff (!rstN)
      (tagQ[g] != '0) |=> (tagQ[g] == '0) || (tagQ[g] == $past(tagQ[g])));
    // R4: the recorded domain holds while the gate stays locked
    a_r4_domain_holds: assert property (@(posedge clk) disable iff (!rstN)
      (tagQ[g] != '0) |=> (tagQ[g] == '0) || (domQ[g] == $past(domQ[g])));
    // R2: an unlocked gate carries no domain
    a_r2_free_no_domain: assert property (@(posedge clk) disable iff (!rstN)
      (tagQ[g] == '0) |-> (domQ[g] == '0));
    // R9: clear-all empties every gate
    a_r9_clear_all_empties: assert property (@(posedge clk) disable iff (!rstN)
      strb.clrAll |=> (tagQ[g] == '0));
  end

  always_comb begin
    rdData = '0;
    for (int g = 0; g < NUM_GATES; g++) begin
      if (addr == ADDR_W'(g)) rdData = DATA_W'({domQ[g], tagQ[g]});
    end
    if (addr == ADDR_W'(NUM_GATES)) rdData = DATA_W'(busy);
  end

  // R2: bits above the domain field read zero on gate reads
  a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr < ADDR_W'(NUM_GATES)) |-> (rdData[DATA_W-1:GATE_W] == '0));
endmodule

// File: rtl/semaGateBank.sv
module semaGateBank
  import semaPkg::*;
#(
  parameter int NUM_GATES = 16,
  parameter int TAG_W     = 4,
  parameter int DOM_W     = 2,
  parameter int ADDR_W    = $clog2(NUM_GATES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  input  logic [TAG_W-1:0]  masterIdx,
  input  logic [DOM_W-1:0]  domainId,
  output logic [15:0]       rdData
);
  localparam int GIDX_W = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1;

  semaStrobes_t      strb;
  logic [GIDX_W-1:0] clrIdx;
  logic              busy;

  semaCtrl #(.NUM_GATES(NUM_GATES), .ADDR_W(ADDR_W), .GIDX_W(GIDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .clrIdx(clrIdx), .busy(busy)
  );

  semaGates #(.NUM_GATES(NUM_GATES), .TAG_W(TAG_W), .DOM_W(DOM_W),
              .ADDR_W(ADDR_W), .GIDX_W(GIDX_W)) uGates (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrTag(wrData[TAG_W-1:0]),
    .masterIdx(masterIdx), .domainId(domainId), .clrIdx(clrIdx), .busy(busy),
    .rdData(rdData)
  );
endmodule

// File: tb/tb_semaGateBank.sv
module tb_semaGateBank;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 16;
  localparam int AW = $clog2(NG + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [3:0] masterIdx = '0;
  logic [1:0] domainId = '0;
  logic [15:0] rdData;

  int nChecks = 0;
  int nFails = 0;
  logic [3:0] mTag [NG];
  logic [1:0] mDom [NG];
  logic mArmed;

  semaGateBank dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
                    .masterIdx(masterIdx), .domainId(domainId), .rdData(rdData));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] expRead(int a);
    if (a < NG) return {10'd0, mDom[a], mTag[a]};
    if (a == NG) return {15'd0, mArmed};
    return 16'd0;
  endfunction

  task automatic modelWrite(int a, logic [15:0] d, logic [3:0] m, logic [1:0] dm);
    logic [4:0] own;
    own = {1'b0, m} + 5'd1;
    if (a < NG) begin
      if (mTag[a] == 0 && d[3:0] != 0 && {1'b0, d[3:0]} == own) begin
        mTag[a] = d[3:0]; mDom[a] = dm;
      end else if (mTag[a] != 0 && d[3:0] == 0 && {1'b0, mTag[a]} == own) begin
        mTag[a] = 0; mDom[a] = 0;
      end
    end else if (a == NG) begin
      if (!mArmed) mArmed = (d[7:0] == 8'hE2);
      else begin
        mArmed = 1'b0;
        if (d[7:0] == 8'h1D) begin
          if (d[15:8] >= NG) begin
            for (int i = 0; i < NG; i++) begin mTag[i] = 0; mDom[i] = 0; end
          end else begin
            mTag[d[15:8]] = 0; mDom[d[15:8]] = 0;
          end
        end
      end
    end
  endtask

  task automatic doWrite(int a, logic [15:0] d, logic [3:0] m, logic [1:0] dm);
    @(negedge clk);
    addr = AW'(a); wrData = d; masterIdx = m; domainId = dm; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d, m, dm);
  endtask

  task automatic check(int a, string req);
    addr = AW'(a);
    #1;
    nChecks++;
    if (rdData !== expRead(a)) begin
      nFails++;
      $display("FAIL %s addr %0d: actual %h expected %h", req, a, rdData, expRead(a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NG; i++) begin mTag[i] = 0; mDom[i] = 0; end
    mArmed = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a <= NG + 1; a++) check(a, "R1");

    doWrite(3, 16'h0003, 4'd2, 2'd1); check(3, "R2");
    doWrite(3, 16'h0001, 4'd0, 2'd3); check(3, "R4 foreign lock");
    doWrite(3, 16'h0000, 4'd0, 2'd3); check(3, "R4 foreign unlock");
    doWrite(5, 16'h0005, 4'd1, 2'd2); check(5, "R3");
    doWrite(3, 16'h0000, 4'd2, 2'd1); check(3, "R5");
    doWrite(17, 16'h0001, 4'd0, 2'd0); check(17, "R6");
    doWrite(15, 16'h000F, 4'd14, 2'd3); check(15, "R2 top gate");
    doWrite(14, 16'h0000, 4'd15, 2'd0); check(14, "R3 idx15");

    doWrite(0, 16'h0001, 4'd0, 2'd2);
    doWrite(7, 16'h0004, 4'd3, 2'd1);
    doWrite(NG, 16'h00E2, 4'd0, 2'd0); check(NG, "R7");
    doWrite(9, 16'h0002, 4'd1, 2'd0); check(NG, "R11"); check(9, "R11 gate");
    doWrite(NG, 16'h071D, 4'd0, 2'd0); check(7, "R8"); check(0, "R8 other"); check(NG, "R8 status");
    doWrite(NG, 16'h00E2, 4'd0, 2'd0);
    doWrite(NG, 16'h0055, 4'd0, 2'd0); check(NG, "R10"); check(0, "R10 keep");
    doWrite(NG, 16'h001D, 4'd0, 2'd0); check(NG, "R7 idle"); check(0, "R7 idle keep");
    doWrite(NG, 16'h00E2, 4'd0, 2'd0);
    doWrite(NG, 16'h101D, 4'd0, 2'd0);
    for (int a = 0; a < NG; a++) check(a, "R9");
    check(NG, "R9 status");

    for (int it = 0; it < 600; it++) begin
      int a, r;
      logic [3:0] m;
      logic [1:0] dm;
      logic [15:0] d;
      m = 4'($urandom % 4);
      dm = 2'($urandom % 4);
      r = $urandom % 10;
      if (r == 0) begin
        a = NG;
        r = $urandom % 3;
        d[7:0] = (r == 0) ? 8'hE2 : (r == 1) ? 8'h1D : 8'($urandom);
        d[15:8] = 8'($urandom % 24);
      end else begin
        a = $urandom % (NG + 2);
        if (a == NG) a = 2;
        r = $urandom % 8;
        d = 16'($urandom) & 16'hFFF0;
        d[3:0] = (r < 5) ? m + 4'd1 : (r < 7) ? 4'd0 : 4'($urandom);
      end
      doWrite(a, d, m, dm);
      check(a, "R2-R6 random");
      check(NG, "R7 random status");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule